// File: doc/BRIEF.md
# Register-Started Transfer Kick Controller

This block lets software launch one block transfer by writing three registers. A destination register and a length register are loaded first. Then a one is written to bit 0 of a control register. The block takes a snapshot of the length and forces the destination to a 32-byte aligned address inside a 29-bit space. It presents the request to an external data mover and holds it there until the mover signals completion.

The block also decodes the aligned destination. When the top nibble (bits 31:28) equals 0x1, a routing flag marks the request for the graphics command-input sink. The flag is clear for every other region.

When the mover reports done, the block drops its busy state, so control bit 0 reads back as zero. In the cycle after done, it raises a one-cycle completion pulse that carries a fixed event number toward the event controller. If the mover delivered fewer bytes than requested, a shortfall flag is latched and stays readable until the next completion.

Top module: `dma_kick`

## Requirements
- R1: After reset, req_valid, evt_valid and every register read (destination, length, control) are zero.
- R2: A write with wr_sel=2 (control) and wr_data bit 0 = 1 while idle makes req_valid high from the next cycle. Control bit 0 reads 1 for as long as the transfer is busy.
- R3: A control write with bit 0 = 0 has no effect: an idle block stays idle and a busy block stays busy.
- R4: req_addr equals the destination register (wr_sel=0) masked with 0x1FFFFFE0 at the moment of start.
- R5: req_len equals the length register (wr_sel=1) sampled at start. Later writes to the length or destination register do not change the active request, and they are used by the next start.
- R6: req_sink is 1 exactly when bits 31:28 of the aligned address equal 0x1.
- R7: mv_done while busy ends the transfer: from the next cycle req_valid is 0 and control bit 0 reads 0.
- R8: In the cycle after a busy mv_done, evt_valid is high for exactly one cycle with evt_id equal to the EVT_NUM parameter (default 19).
- R9: Control bit 1 (shortfall) is set at completion when mv_bytes < req_len, cleared at completion otherwise, and held between completions.
- R10: A start written while busy is ignored: the request fields stay unchanged and only one completion event follows.
- R11: mv_done while idle is ignored and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select: 0 destination, 1 length, 2 control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding as wr_sel |
| rd_data | output | 32 | Read data; for control, bit 0 busy, bit 1 shortfall |
| req_valid | output | 1 | Transfer request to the data mover, held until done |
| req_addr | output | 32 | Aligned destination address |
| req_len | output | 32 | Requested byte count |
| req_sink | output | 1 | Destination lies in the command-input sink region |
| mv_done | input | 1 | Data mover completion strobe |
| mv_bytes | input | 32 | Bytes actually delivered, valid with mv_done |
| evt_valid | output | 1 | One-cycle completion event |
| evt_id | output | 6 | Completion event number |

## Verification
A corrupted sequencer state appears at the ports within one cycle. req_valid either fails to rise after a start or fails to fall after done, and the completion pulse then goes missing or repeats. A wrongly captured request shows as mismatching address, length or sink flag on the first cycle req_valid is high. A stale shortfall flag shows on the control read in the same cycle as the completion event.

// File: rtl/dmak_pkg.sv
package dmak_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SEL_W  = 2;

    localparam int unsigned CTRL_BUSY_BIT  = 0;
    localparam int unsigned CTRL_SHORT_BIT = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_DEST  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] len;
        logic              sink;
    } xfer_req_t;

    // Ones in bit positions lo..hi, zeros elsewhere.
    function automatic logic [WORD_W-1:0] window_mask(int unsigned lo, int unsigned hi);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < WORD_W; b++) begin
            if (b >= lo && b <= hi) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dmak_regfile.sv
module dmak_regfile
    import dmak_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              busy,
    input  logic              short_q,
    output logic [WORD_W-1:0] dest_q,
    output logic [WORD_W-1:0] count_q,
    output logic              kick,
    output logic [WORD_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q  <= '0;
            count_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_DEST)  dest_q  <= wr_data;
            if (wr_sel == SEL_COUNT) count_q <= wr_data;
        end
    end

    // Only a one in the start bit means anything; a zero is dropped.
    assign kick = wr_en && (wr_sel == SEL_CTRL) && wr_data[CTRL_BUSY_BIT];

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_DEST:  rd_data = dest_q;
            SEL_COUNT: rd_data = count_q;
            SEL_CTRL: begin
                rd_data[CTRL_BUSY_BIT]  = busy;
                rd_data[CTRL_SHORT_BIT] = short_q;
            end
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dmak_seq.sv
module dmak_seq
    import dmak_pkg::*;
#(
    parameter int unsigned ALIGN_LSB   = 5,
    parameter int unsigned SPACE_MSB   = 28,
    parameter int unsigned REGION_W    = 4,
    parameter logic [REGION_W-1:0] SINK_REGION = 4'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [WORD_W-1:0] dest_q,
    input  logic [WORD_W-1:0] count_q,
    input  logic              mv_done,
    output logic              busy,
    output xfer_req_t         req,
    output logic              finish
);

    localparam logic [WORD_W-1:0] ADDR_MASK = window_mask(ALIGN_LSB, SPACE_MSB);
    localparam int unsigned REGION_LSB = WORD_W - REGION_W;

    seq_state_e        state;
    logic [WORD_W-1:0] aligned;
    logic              in_sink;

    assign aligned = dest_q & ADDR_MASK;
    assign in_sink = (aligned[WORD_W-1:REGION_LSB] == SINK_REGION);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (kick) begin
                        state    <= ST_BUSY;
                        req.addr <= aligned;
                        req.len  <= count_q;
                        req.sink <= in_sink;
                    end
                end
                ST_BUSY: begin
                    if (mv_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state == ST_BUSY);
    assign finish = busy && mv_done;

endmodule

// File: rtl/dmak_event.sv
module dmak_event
    import dmak_pkg::*;
#(
    parameter int unsigned EVT_W   = 6,
    parameter int unsigned EVT_NUM = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              finish,
    input  logic [WORD_W-1:0] mv_bytes,
    input  logic [WORD_W-1:0] req_len,
    output logic              evt_valid,
    output logic [EVT_W-1:0]  evt_id,
    output logic              short_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid <= 1'b0;
            short_q   <= 1'b0;
        end else begin
            evt_valid <= finish;
            if (finish) short_q <= (mv_bytes < req_len);
        end
    end

    assign evt_id = EVT_W'(EVT_NUM);

endmodule

// File: rtl/dma_kick.sv
module dma_kick
    import dmak_pkg::*;
#(
    parameter int unsigned ALIGN_LSB   = 5,
    parameter int unsigned SPACE_MSB   = 28,
    parameter int unsigned REGION_W    = 4,
    parameter logic [REGION_W-1:0] SINK_REGION = 4'h1,
    parameter int unsigned EVT_W       = 6,
    parameter int unsigned EVT_NUM     = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              req_valid,
    output logic [WORD_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_len,
    output logic              req_sink,
    input  logic              mv_done,
    input  logic [WORD_W-1:0] mv_bytes,
    output logic              evt_valid,
    output logic [EVT_W-1:0]  evt_id
);

    logic [WORD_W-1:0] dest_q;
    logic [WORD_W-1:0] count_q;
    logic              kick;
    logic              busy;
    logic              finish;
    logic              short_q;
    xfer_req_t         req;

    dmak_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .busy    (busy),
        .short_q (short_q),
        .dest_q  (dest_q),
        .count_q (count_q),
        .kick    (kick),
        .rd_data (rd_data)
    );

    dmak_seq #(
        .ALIGN_LSB   (ALIGN_LSB),
        .SPACE_MSB   (SPACE_MSB),
        .REGION_W    (REGION_W),
        .SINK_REGION (SINK_REGION)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .kick    (kick),
        .dest_q  (dest_q),
        .count_q (count_q),
        .mv_done (mv_done),
        .busy    (busy),
        .req     (req),
        .finish  (finish)
    );

    dmak_event #(
        .EVT_W   (EVT_W),
        .EVT_NUM (EVT_NUM)
    ) u_evt (
        .clk       (clk),
        .rst       (rst),
        .finish    (finish),
        .mv_bytes  (mv_bytes),
        .req_len   (req.len),
        .evt_valid (evt_valid),
        .evt_id    (evt_id),
        .short_q   (short_q)
    );

    assign req_valid = busy;
    assign req_addr  = req.addr;
    assign req_len   = req.len;
    assign req_sink  = req.sink;

endmodule

// File: rtl/dma_kick_chk.sv
module dma_kick_chk
    import dmak_pkg::*;
#(
    parameter int unsigned ALIGN_LSB   = 5,
    parameter int unsigned SPACE_MSB   = 28,
    parameter int unsigned REGION_W    = 4,
    parameter logic [REGION_W-1:0] SINK_REGION = 4'h1,
    parameter int unsigned EVT_W       = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              req_valid,
    input logic [WORD_W-1:0] req_addr,
    input logic [WORD_W-1:0] req_len,
    input logic              req_sink,
    input logic              mv_done,
    input logic              evt_valid,
    input logic [EVT_W-1:0]  evt_id
);

    localparam logic [WORD_W-1:0] KEEP = window_mask(ALIGN_LSB, SPACE_MSB);

    logic start_wr;
    assign start_wr = wr_en && (wr_sel == SEL_CTRL) && wr_data[CTRL_BUSY_BIT];

    a_r2_start_raises_req: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && start_wr) |=> req_valid);

    a_r3_no_start_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !start_wr) |=> !req_valid);

    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_addr & ~KEEP) == '0));

    a_r6_sink_matches_addr: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_sink == (req_addr[WORD_W-1:WORD_W-REGION_W] == SINK_REGION)));

    a_r10_req_held_while_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mv_done) |=> (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_sink)));

    a_r7_done_drops_req: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mv_done) |=> !req_valid);

    a_r8_event_follows_done: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mv_done) |=> evt_valid);

    a_r8_event_one_cycle: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !evt_valid);

    a_r11_idle_done_silent: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && mv_done) |=> !evt_valid);

endmodule

bind dma_kick dma_kick_chk #(
    .ALIGN_LSB   (ALIGN_LSB),
    .SPACE_MSB   (SPACE_MSB),
    .REGION_W    (REGION_W),
    .SINK_REGION (SINK_REGION),
    .EVT_W       (EVT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_sink  (req_sink),
    .mv_done   (mv_done),
    .evt_valid (evt_valid),
    .evt_id    (evt_id)
);

// File: tb/test_dma_kick.sv
module test_dma_kick;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd2;
    logic [31:0] rd_data;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [31:0] req_len;
    logic        req_sink;
    logic        mv_done = 1'b0;
    logic [31:0] mv_bytes = '0;
    logic        evt_valid;
    logic [5:0]  evt_id;

    dma_kick i_dma_kick (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_sink(req_sink), .mv_done(mv_done), .mv_bytes(mv_bytes),
        .evt_valid(evt_valid), .evt_id(evt_id)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] len;
        logic        sink;
        logic        shrt;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    int          delay_cfg = 2;
    logic [31:0] deliver_cfg = '0;
    bit          spurious = 1'b0;
    bit          finished = 1'b0;
    bit          mon_on = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic exp_t make_exp(input logic [31:0] dest, input logic [31:0] cnt,
                                      input logic [31:0] got);
        exp_t e;
        e.addr = dest & 32'h1FFF_FFE0;
        e.len  = cnt;
        e.sink = (e.addr[31:28] == 4'h1);
        e.shrt = (got < cnt);
        return e;
    endfunction

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
    endtask

    // Driver: loads registers, pushes the expected completion, starts.
    task automatic run_xfer(input logic [31:0] dest, input logic [31:0] cnt,
                            input logic [31:0] got, input int dly);
        int target;
        target = done_cnt + 1;
        reg_write(2'd0, dest);
        reg_write(2'd1, cnt);
        deliver_cfg = got;
        delay_cfg = dly;
        sb.push_back(make_exp(dest, cnt, got));
        reg_write(2'd2, 32'h1);
        wait_done(target);
    endtask

    // Data mover model.
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                repeat (delay_cfg) @(negedge clk);
                mv_bytes = deliver_cfg;
                mv_done = 1'b1;
                @(negedge clk);
                mv_done = 1'b0;
            end else if (spurious) begin
                spurious = 1'b0;
                mv_bytes = 32'h0;
                mv_done = 1'b1;
                @(negedge clk);
                mv_done = 1'b0;
            end
        end
    end

    // Monitor: compares the request on its first cycle and pops on each event.
    initial begin
        logic prev_req = 1'b0;
        logic prev_evt = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (req_valid && !prev_req) begin
                    if (sb.size() == 0) begin
                        check("R10 unexpected request", 32'h1, 32'h0);
                    end else begin
                        check("R4 req_addr", req_addr, sb[0].addr);
                        check("R5 req_len", req_len, sb[0].len);
                        check("R6 req_sink", {31'b0, req_sink}, {31'b0, sb[0].sink});
                        check("R2 ctrl busy bit", {31'b0, rd_data[0]}, 32'h1);
                    end
                end
                if (prev_evt) check("R8 event one cycle", {31'b0, evt_valid}, 32'h0);
                if (evt_valid) begin
                    if (sb.size() == 0) begin
                        check("R10 extra completion event", 32'h1, 32'h0);
                    end else begin
                        check("R8 evt_id", {26'b0, evt_id}, 32'd19);
                        check("R7 req dropped", {31'b0, req_valid}, 32'h0);
                        check("R7 ctrl busy clear", {31'b0, rd_data[0]}, 32'h0);
                        check("R9 shortfall flag", {31'b0, rd_data[1]}, {31'b0, sb[0].shrt});
                        void'(sb.pop_front());
                    end
                    done_cnt++;
                end
            end
            prev_req = req_valid;
            prev_evt = evt_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int target;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 req_valid", {31'b0, req_valid}, 32'h0);
        check("R1 evt_valid", {31'b0, evt_valid}, 32'h0);
        rd_sel = 2'd0; #1;
        check("R1 dest reg", rd_data, 32'h0);
        rd_sel = 2'd1; #1;
        check("R1 count reg", rd_data, 32'h0);
        rd_sel = 2'd2; #1;
        check("R1 ctrl reg", rd_data, 32'h0);
        mon_on = 1'b1;

        // R3: zero written to control while idle
        reg_write(2'd2, 32'h0);
        check("R3 idle zero write", {31'b0, req_valid}, 32'h0);

        // R11: done while idle
        spurious = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 no event", {31'b0, evt_valid}, 32'h0);
        check("R11 event count", done_cnt, 0);

        // Main transfers
        run_xfer(32'h1234_5678, 32'd64, 32'd64, 2);
        run_xfer(32'h0C00_0047, 32'd32, 32'd20, 1);
        check("R9 short held", {31'b0, rd_data[1]}, 32'h1);
        run_xfer(32'hF000_001F, 32'h100, 32'h100, 3);
        check("R9 short cleared", {31'b0, rd_data[1]}, 32'h0);
        run_xfer(32'h2FFF_FFFF, 32'h40, 32'h3F, 0);

        // R10 / R3 / R5: writes during a busy transfer
        target = done_cnt + 1;
        reg_write(2'd0, 32'h0000_0100);
        reg_write(2'd1, 32'h80);
        deliver_cfg = 32'h80;
        delay_cfg = 12;
        sb.push_back(make_exp(32'h0000_0100, 32'h80, 32'h80));
        reg_write(2'd2, 32'h1);
        reg_write(2'd1, 32'h200);
        reg_write(2'd0, 32'h1000_0000);
        reg_write(2'd2, 32'h0);
        check("R3 busy zero write", {31'b0, req_valid}, 32'h1);
        reg_write(2'd2, 32'h1);
        check("R10 addr kept", req_addr, 32'h0000_0100);
        check("R10 len kept", req_len, 32'h80);
        check("R10 still busy", {31'b0, rd_data[0]}, 32'h1);
        wait_done(target);
        repeat (4) @(negedge clk);
        check("R10 single event", done_cnt, target);

        // R5: next start uses the registers written while busy
        target = done_cnt + 1;
        deliver_cfg = 32'h200;
        delay_cfg = 1;
        sb.push_back(make_exp(32'h1000_0000, 32'h200, 32'h200));
        reg_write(2'd2, 32'h1);
        wait_done(target);
        repeat (3) @(negedge clk);
        check("R8 queue drained", sb.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule